// File: doc/BRIEF.md
# Micro-Sequenced Accumulator Processor

This block is a compact accumulator machine whose every instruction runs as a fixed chain of one-cycle register transfers. The transfers move data among a program counter, a memory address register, a memory data register, an instruction register, an accumulator, a stack pointer and an ALU whose result is registered. A sequencer walks through four phases: fetch with operand addressing, a pointer-chasing phase, execute, and interrupt entry. A decoder turns the phase and step into a word of transfer enables, so the same register file carries every instruction.

Memory is reached through one single-port interface. The address always comes from the memory address register, and the write data always comes from the memory data register. Read data must be valid in the same cycle as the read strobe, and it is captured at that cycle's rising edge. A write strobe commits at the rising edge. Instruction words are 16 bits: the opcode is in bits 15:12, bit 11 requests indirect addressing, and bits 10:0 hold the address field. Reset is synchronous and active low.

Top module: `accu_seq_cpu`

## Requirements
- R1: Each instruction begins with three fetch cycles. The first cycle has no strobe. The second reads at the current PC, and the PC then advances by one, wrapping at 11 bits. The third cycle has no strobe.
- R2: When bit 11 of the instruction is clear, two cycles follow the fetch. The first has no strobe, and the second reads at the 11-bit address field. The word read there is the operand.
- R3: When bit 11 is set, four cycles follow the fetch. Their strobes are: none, a read at the address field, none, and a read at bits 10:0 of the first word read. That pointer replaces the address field, so later writes and jumps use it.
- R4: Opcode 1 (add-to-memory) takes four execute cycles, with a write only in the last. That write stores AC plus the operand, modulo 2^16, at the effective address, and AC keeps the sum.
- R5: Opcode 2 (increment and skip) takes three execute cycles, with a write only in the last. That write stores the operand plus one at the effective address. When the stored value is zero, the PC advances once more, so the next instruction word is passed over.
- R6: Opcode 3 (call) takes three execute cycles. The second cycle writes the address of the following instruction at SP, and SP then grows by one. The next fetch reads at the effective address.
- R7: Any other opcode takes one execute cycle with no strobe. It changes no memory and no register other than the PC advance made during fetch.
- R8: An interrupt is entered only when irq and irq_enable are both high in the final execute cycle. The irq level in any other cycle is ignored. Entry takes five cycles with strobes: none, a write of PC at SP (after which SP grows by one), none, a read at INT_VEC, and none. The next fetch reads at bits 10:0 of the vector word.
- R9: After reset the PC is 0, SP is STACK_BASE and AC is 0. No strobe is active while reset is held, and the first cycle after reset is fetch cycle one.
- R10: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq | input | 1 | Interrupt request level |
| irq_enable | input | 1 | Permits interrupt entry when high |
| mem_addr | output | ADDR_W (11) | Memory address, taken from the address register |
| mem_rd | output | 1 | Read strobe; data is captured at this cycle's edge |
| mem_wr | output | 1 | Write strobe; the write commits at this cycle's edge |
| mem_wdata | output | DATA_W (16) | Write data, taken from the data register |
| mem_rdata | input | DATA_W (16) | Read data, valid in the strobe cycle |

## Verification
A behavioural model in the bench predicts the strobes, address and write data of every cycle, and the bench compares them with the design on each clock. The program runs each opcode with direct and indirect operands. Increments that wrap to zero, and increments that do not, show whether the skip is taken. A call reached through a pointer shows that the pointer replaces the address field. Unassigned opcodes with non-zero fields show that nothing is disturbed. The interrupt request is raised three ways: in the final execute cycle with the enable high, with the enable low, and only in an earlier execute cycle. Only the first may divert the flow to the vector. Two entries stacked on top of calls show whether SP sequencing and the saved return addresses are right.

// File: rtl/accu_pkg.sv
package accu_pkg;

   localparam int OPC_W  = 4;
   localparam int STEP_W = 3;

   localparam logic [OPC_W-1:0] OPC_SUM  = 4'h1;
   localparam logic [OPC_W-1:0] OPC_ISZ  = 4'h2;
   localparam logic [OPC_W-1:0] OPC_CALL = 4'h3;

   typedef enum logic [1:0] {
      PH_FETCH = 2'd0,
      PH_INDIR = 2'd1,
      PH_EXEC  = 2'd2,
      PH_INTR  = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      ALU_NONE = 2'd0,
      ALU_ADD  = 2'd1,
      ALU_INC  = 2'd2
   } alu_op_e;

   typedef enum logic [1:0] {
      ASRC_AC  = 2'd0,
      ASRC_MBR = 2'd1,
      ASRC_SP  = 2'd2
   } alu_src_e;

   // One enable per register transfer; at most one source per destination.
   typedef struct packed {
      logic     mar_pc;
      logic     mar_ir;
      logic     mar_mbr;
      logic     mar_sp;
      logic     mar_vec;
      logic     mbr_mem;
      logic     mbr_pc;
      logic     mbr_ac;
      logic     mbr_alu;
      logic     ir_mbr;
      logic     ir_addr_mbr;
      logic     pc_inc;
      logic     pc_inc_zero;
      logic     pc_ir;
      logic     pc_mbr;
      logic     ac_alu;
      logic     sp_alu;
      logic     sp_inc;
      logic     rd;
      logic     wr;
      alu_op_e  alu_op;
      alu_src_e alu_src;
   } xfer_t;

endpackage

// File: rtl/accu_alu.sv
module accu_alu
   import accu_pkg::*;
#(
   parameter int W            = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  alu_op_e       op,
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   output logic [W-1:0]  q
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] sum;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [W-1:0] addend;
         assign addend = (op == ALU_INC) ? ONE : b;
         assign sum    = a + addend;
      end else begin : g_split
         logic [W-1:0] inc_res;
         logic [W-1:0] add_res;
         assign inc_res = a + ONE;
         assign add_res = a + b;
         assign sum     = (op == ALU_INC) ? inc_res : add_res;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                q <= '0;
      else if (op != ALU_NONE)   q <= sum;
   end

endmodule

// File: rtl/accu_seq_ctrl.sv
module accu_seq_ctrl
   import accu_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [OPC_W-1:0]    opcode,
   input  logic                ind_bit,
   input  logic                irq_take,
   output phase_e              phase,
   output logic [STEP_W-1:0]   step
);

   logic [STEP_W-1:0] exec_last;

   always_comb begin
      unique case (opcode)
         OPC_SUM:  exec_last = STEP_W'(3);
         OPC_ISZ:  exec_last = STEP_W'(2);
         OPC_CALL: exec_last = STEP_W'(2);
         default:  exec_last = STEP_W'(0);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_FETCH;
         step  <= '0;
      end else begin
         unique case (phase)
            PH_FETCH: begin
               if (step == STEP_W'(4)) begin
                  phase <= ind_bit ? PH_INDIR : PH_EXEC;
                  step  <= '0;
               end else begin
                  step  <= step + 1'b1;
               end
            end
            PH_INDIR: begin
               if (step == STEP_W'(1)) begin
                  phase <= PH_EXEC;
                  step  <= '0;
               end else begin
                  step  <= step + 1'b1;
               end
            end
            PH_EXEC: begin
               if (step == exec_last) begin
                  phase <= irq_take ? PH_INTR : PH_FETCH;
                  step  <= '0;
               end else begin
                  step  <= step + 1'b1;
               end
            end
            default: begin
               if (step == STEP_W'(4)) begin
                  phase <= PH_FETCH;
                  step  <= '0;
               end else begin
                  step  <= step + 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/accu_xfer_dec.sv
module accu_xfer_dec
   import accu_pkg::*;
(
   input  phase_e              phase,
   input  logic [STEP_W-1:0]   step,
   input  logic [OPC_W-1:0]    opcode,
   output xfer_t               ctl
);

   always_comb begin
      ctl = '0;
      unique case (phase)
         PH_FETCH: begin
            unique case (step)
               3'd0: ctl.mar_pc = 1'b1;
               3'd1: begin ctl.rd = 1'b1; ctl.mbr_mem = 1'b1; ctl.pc_inc = 1'b1; end
               3'd2: ctl.ir_mbr = 1'b1;
               3'd3: ctl.mar_ir = 1'b1;
               default: begin ctl.rd = 1'b1; ctl.mbr_mem = 1'b1; end
            endcase
         end
         PH_INDIR: begin
            if (step == 3'd0) begin
               ctl.mar_mbr     = 1'b1;
               ctl.ir_addr_mbr = 1'b1;
            end else begin
               ctl.rd      = 1'b1;
               ctl.mbr_mem = 1'b1;
            end
         end
         PH_EXEC: begin
            unique case (opcode)
               OPC_SUM: begin
                  unique case (step)
                     3'd0: begin ctl.alu_op = ALU_ADD; ctl.alu_src = ASRC_AC; end
                     3'd1: ctl.ac_alu = 1'b1;
                     3'd2: begin ctl.mbr_ac = 1'b1; ctl.mar_ir = 1'b1; end
                     default: ctl.wr = 1'b1;
                  endcase
               end
               OPC_ISZ: begin
                  unique case (step)
                     3'd0: begin ctl.alu_op = ALU_INC; ctl.alu_src = ASRC_MBR; end
                     3'd1: ctl.mbr_alu = 1'b1;
                     default: begin ctl.wr = 1'b1; ctl.pc_inc_zero = 1'b1; end
                  endcase
               end
               OPC_CALL: begin
                  unique case (step)
                     3'd0: begin ctl.mbr_pc = 1'b1; ctl.mar_sp = 1'b1; end
                     3'd1: begin ctl.wr = 1'b1; ctl.alu_op = ALU_INC; ctl.alu_src = ASRC_SP; end
                     default: begin ctl.pc_ir = 1'b1; ctl.sp_alu = 1'b1; end
                  endcase
               end
               default: ;
            endcase
         end
         default: begin
            unique case (step)
               3'd0: begin ctl.mbr_pc = 1'b1; ctl.mar_sp = 1'b1; end
               3'd1: begin ctl.wr = 1'b1; ctl.sp_inc = 1'b1; end
               3'd2: ctl.mar_vec = 1'b1;
               3'd3: begin ctl.rd = 1'b1; ctl.mbr_mem = 1'b1; end
               default: ctl.pc_mbr = 1'b1;
            endcase
         end
      endcase
   end

endmodule

// File: rtl/accu_seq_cpu.sv
module accu_seq_cpu
   import accu_pkg::*;
#(
   parameter int                DATA_W       = 16,
   parameter int                ADDR_W       = 11,
   parameter logic [ADDR_W-1:0] STACK_BASE   = 11'h600,
   parameter logic [ADDR_W-1:0] INT_VEC      = 11'h7F0,
   parameter bit                SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq,
   input  logic              irq_enable,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int OPC_LSB = DATA_W - OPC_W;
   localparam int IND_BIT = OPC_LSB - 1;
   localparam int EXT_W   = DATA_W - ADDR_W;

   generate
      if (ADDR_W + 1 + OPC_W != DATA_W) begin : g_bad_format
         $error("instruction word must hold opcode, indirect bit and address field exactly");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("address field too narrow");
      end
   endgenerate

   logic [ADDR_W-1:0] pc_q, mar_q, sp_q;
   logic [DATA_W-1:0] mbr_q, ir_q, ac_q;
   logic [DATA_W-1:0] alu_a, alu_q;
   logic [OPC_W-1:0]  opcode;
   logic [ADDR_W-1:0] ir_addr;
   phase_e            phase;
   logic [STEP_W-1:0] step;
   xfer_t             ctl;
   logic              skip_hit;

   assign opcode  = ir_q[DATA_W-1:OPC_LSB];
   assign ir_addr = ir_q[ADDR_W-1:0];

   accu_seq_ctrl u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .opcode   (opcode),
      .ind_bit  (ir_q[IND_BIT]),
      .irq_take (irq & irq_enable),
      .phase    (phase),
      .step     (step)
   );

   accu_xfer_dec u_dec (
      .phase  (phase),
      .step   (step),
      .opcode (opcode),
      .ctl    (ctl)
   );

   always_comb begin
      unique case (ctl.alu_src)
         ASRC_AC:  alu_a = ac_q;
         ASRC_SP:  alu_a = {{EXT_W{1'b0}}, sp_q};
         default:  alu_a = mbr_q;
      endcase
   end

   accu_alu #(.W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (ctl.alu_op),
      .a     (alu_a),
      .b     (mbr_q),
      .q     (alu_q)
   );

   assign skip_hit = ctl.pc_inc_zero && (mbr_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= '0;
         mar_q <= '0;
         sp_q  <= STACK_BASE;
         mbr_q <= '0;
         ir_q  <= '0;
         ac_q  <= '0;
      end else begin
         if      (ctl.mar_pc)  mar_q <= pc_q;
         else if (ctl.mar_ir)  mar_q <= ir_addr;
         else if (ctl.mar_mbr) mar_q <= mbr_q[ADDR_W-1:0];
         else if (ctl.mar_sp)  mar_q <= sp_q;
         else if (ctl.mar_vec) mar_q <= INT_VEC;

         if      (ctl.mbr_mem) mbr_q <= mem_rdata;
         else if (ctl.mbr_pc)  mbr_q <= {{EXT_W{1'b0}}, pc_q};
         else if (ctl.mbr_ac)  mbr_q <= ac_q;
         else if (ctl.mbr_alu) mbr_q <= alu_q;

         if      (ctl.ir_mbr)      ir_q <= mbr_q;
         else if (ctl.ir_addr_mbr) ir_q[ADDR_W-1:0] <= mbr_q[ADDR_W-1:0];

         if      (ctl.pc_inc || skip_hit) pc_q <= pc_q + 1'b1;
         else if (ctl.pc_ir)              pc_q <= ir_addr;
         else if (ctl.pc_mbr)             pc_q <= mbr_q[ADDR_W-1:0];

         if (ctl.ac_alu) ac_q <= alu_q;

         if      (ctl.sp_alu) sp_q <= alu_q[ADDR_W-1:0];
         else if (ctl.sp_inc) sp_q <= sp_q + 1'b1;
      end
   end

   assign mem_addr  = mar_q;
   assign mem_wdata = mbr_q;
   assign mem_rd    = ctl.rd;
   assign mem_wr    = ctl.wr;

endmodule

// File: rtl/accu_seq_cpu_chk.sv
module accu_seq_cpu_chk
   import accu_pkg::*;
#(
   parameter int                DATA_W  = 16,
   parameter int                ADDR_W  = 11,
   parameter logic [ADDR_W-1:0] INT_VEC = 11'h7F0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              irq_enable,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [DATA_W-1:0] mem_wdata,
   input phase_e            phase,
   input logic [STEP_W-1:0] step,
   input logic [OPC_W-1:0]  opcode,
   input logic [ADDR_W-1:0] pc,
   input logic [ADDR_W-1:0] sp,
   input logic [ADDR_W-1:0] ir_addr
);

   a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   a_r1_fetch_at_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_FETCH && step == 3'd1) |-> (mem_rd && mem_addr == pc));

   a_r1_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_FETCH && step == 3'd1) |=> (pc == $past(pc) + 1'b1));

   a_r3_pointer_used: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_INDIR && step == 3'd0) |=>
         (mem_addr == $past(mem_wdata[ADDR_W-1:0]) && ir_addr == mem_addr));

   a_r5_skip_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXEC && opcode == OPC_ISZ && step == 3'd2 && mem_wdata == '0)
         |=> (pc == $past(pc) + 1'b1));

   a_r6_call_target: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXEC && opcode == OPC_CALL && step == 3'd2)
         |=> (sp == $past(sp) + 1'b1 && pc == $past(ir_addr)));

   a_r8_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_INTR && step == 3'd0) |-> $past(irq && irq_enable));

   a_r8_vector_read: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_INTR && step == 3'd3) |-> (mem_rd && mem_addr == INT_VEC));

endmodule

bind accu_seq_cpu accu_seq_cpu_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .INT_VEC (INT_VEC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq        (irq),
   .irq_enable (irq_enable),
   .mem_addr   (mem_addr),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .mem_wdata  (mem_wdata),
   .phase      (phase),
   .step       (step),
   .opcode     (opcode),
   .pc         (pc_q),
   .sp         (sp_q),
   .ir_addr    (ir_addr)
);

// File: tb/test_accu_seq_cpu.sv
`timescale 1ns/1ps
module test_accu_seq_cpu;

   localparam logic [10:0] STACK_BASE = 11'h600;
   localparam logic [10:0] INT_VEC    = 11'h7F0;
   localparam int          N_INSTR    = 24;

   typedef struct {
      bit          rd;
      bit          wr;
      logic [10:0] addr;
      logic [15:0] wdata;
      bit          irq;
      bit          ien;
      string       req;
   } cyc_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        irq;
   logic        irq_enable;
   logic [10:0] mem_addr;
   logic        mem_rd;
   logic        mem_wr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;

   logic [15:0] mem  [0:2047];
   logic [15:0] mmem [0:2047];

   cyc_t        q [$];
   logic [10:0] m_pc, m_sp;
   logic [15:0] m_ac;
   int          icount = 0;
   int          total  = 0;
   int          bad    = 0;
   int          cyc_no = 0;

   always #10 clk = ~clk;

   accu_seq_cpu #(.STACK_BASE(STACK_BASE), .INT_VEC(INT_VEC)) i_accu_seq_cpu (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq        (irq),
      .irq_enable (irq_enable),
      .mem_addr   (mem_addr),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata)
   );

   assign mem_rdata = mem[mem_addr];

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
   end

   task automatic push(bit rd, bit wr, logic [10:0] a, logic [15:0] d, string req);
      cyc_t e;
      e.rd = rd; e.wr = wr; e.addr = a; e.wdata = d;
      e.irq = 1'b0; e.ien = 1'b1; e.req = req;
      q.push_back(e);
   endtask

   // Instruction-level reference: expands one instruction into its bus cycles.
   task automatic gen_instr();
      logic [15:0] w, opnd, v;
      logic [10:0] ea;
      int          first, last;
      push(0, 0, '0, '0, "R1");
      push(1, 0, m_pc, '0, "R1");
      push(0, 0, '0, '0, "R1");
      w    = mmem[m_pc];
      m_pc = m_pc + 1'b1;
      ea   = w[10:0];
      push(0, 0, '0, '0, w[11] ? "R3" : "R2");
      push(1, 0, ea, '0, w[11] ? "R3" : "R2");
      if (w[11]) begin
         push(0, 0, '0, '0, "R3");
         ea = mmem[ea][10:0];
         push(1, 0, ea, '0, "R3");
      end
      opnd  = mmem[ea];
      first = q.size();
      case (w[15:12])
         4'h1: begin
            m_ac = m_ac + opnd;
            push(0, 0, '0, '0, "R4"); push(0, 0, '0, '0, "R4"); push(0, 0, '0, '0, "R4");
            push(0, 1, ea, m_ac, "R4");
            mmem[ea] = m_ac;
         end
         4'h2: begin
            v = opnd + 16'd1;
            push(0, 0, '0, '0, "R5"); push(0, 0, '0, '0, "R5");
            push(0, 1, ea, v, "R5");
            mmem[ea] = v;
            if (v == 16'd0) m_pc = m_pc + 1'b1;
         end
         4'h3: begin
            push(0, 0, '0, '0, "R6");
            push(0, 1, m_sp, {5'b0, m_pc}, "R6");
            mmem[m_sp] = {5'b0, m_pc};
            m_sp = m_sp + 1'b1;
            m_pc = ea;
            push(0, 0, '0, '0, "R6");
         end
         default: push(0, 0, '0, '0, "R7");
      endcase
      last = q.size() - 1;
      // R8 stimulus: taken, disabled, and asserted only before the final cycle
      if (icount == 4 || icount == 13) begin q[last].irq = 1'b1; q[last].req = "R8"; end
      if (icount == 7) begin q[last].irq = 1'b1; q[last].ien = 1'b0; q[last].req = "R8"; end
      if (icount == 11) begin q[first].irq = 1'b1; q[first].req = "R8"; end
      if (q[last].irq && q[last].ien) begin
         push(0, 0, '0, '0, "R8");
         push(0, 1, m_sp, {5'b0, m_pc}, "R8");
         mmem[m_sp] = {5'b0, m_pc};
         m_sp = m_sp + 1'b1;
         push(0, 0, '0, '0, "R8");
         push(1, 0, INT_VEC, '0, "R8");
         push(0, 0, '0, '0, "R8");
         m_pc = mmem[INT_VEC][10:0];
      end
      icount++;
   endtask

   task automatic put(int a, logic [15:0] d);
      mem[a]  = d;
      mmem[a] = d;
   endtask

   task automatic check_cycle(cyc_t e);
      bit ok;
      total++;
      ok = (mem_rd == e.rd) && (mem_wr == e.wr);
      if ((e.rd || e.wr) && mem_addr != e.addr) ok = 1'b0;
      if (e.wr && mem_wdata != e.wdata) ok = 1'b0;
      if (!ok) begin
         bad++;
         $display("FAIL %s cycle %0d: act rd=%0b wr=%0b addr=%h data=%h exp rd=%0b wr=%0b addr=%h data=%h",
                  e.req, cyc_no, mem_rd, mem_wr, mem_addr, mem_wdata,
                  e.rd, e.wr, e.addr, e.wdata);
      end
      total++;
      if (mem_rd && mem_wr) begin
         bad++;
         $display("FAIL R10 cycle %0d: act rd=1 wr=1 exp at most one strobe", cyc_no);
      end
   endtask

   initial begin
      cyc_t e;
      for (int a = 0; a < 2048; a++) begin mem[a] = '0; mmem[a] = '0; end
      // main program
      put(11'h000, 16'h1200);          // add-to-memory direct
      put(11'h001, 16'h1201);
      put(11'h002, 16'h2202);          // increment wraps to zero: skip
      put(11'h003, 16'h1203);          // passed over
      put(11'h004, 16'h2204);          // increment, no skip
      put(11'h005, 16'h1A05);          // add-to-memory indirect
      put(11'h006, 16'h3300);          // call
      put(11'h300, 16'h2A06);          // increment indirect, wraps: skip
      put(11'h301, 16'h120A);
      put(11'h302, 16'h3A07);          // call indirect
      put(11'h400, 16'hF123);          // unassigned opcode
      put(11'h401, 16'h2209);
      put(11'h500, 16'h1208);          // handler
      put(11'h501, 16'h3006);
      put(INT_VEC, 16'hF500);
      put(11'h200, 16'd5);
      put(11'h201, 16'd7);
      put(11'h202, 16'hFFFF);
      put(11'h203, 16'd40);
      put(11'h204, 16'd3);
      put(11'h205, 16'hF210);          // pointer with upper bits set
      put(11'h206, 16'h0211);
      put(11'h207, 16'h0400);
      put(11'h208, 16'd1);
      put(11'h209, 16'hFFFE);
      put(11'h20A, 16'd9);
      put(11'h210, 16'd100);
      put(11'h211, 16'hFFFF);
      m_pc = '0; m_sp = STACK_BASE; m_ac = '0;

      rst_n = 1'b0; irq = 1'b0; irq_enable = 1'b0;
      repeat (3) @(negedge clk);
      total++;
      if (mem_rd || mem_wr) begin
         bad++;
         $display("FAIL R9 reset: act rd=%0b wr=%0b exp rd=0 wr=0", mem_rd, mem_wr);
      end
      rst_n = 1'b1;
      while (icount < N_INSTR || q.size() > 0) begin
         if (q.size() == 0) gen_instr();
         e = q.pop_front();
         irq        = e.irq;
         irq_enable = e.ien;
         check_cycle(e);
         cyc_no++;
         @(negedge clk);
      end
      irq = 1'b0;
      for (int a = 11'h200; a <= 11'h211; a++) begin
         total++;
         if (mem[a] !== mmem[a]) begin
            bad++;
            $display("FAIL R4 memory[%h]: act %h exp %h", a, mem[a], mmem[a]);
         end
      end
      for (int a = STACK_BASE; a < STACK_BASE + 8; a++) begin
         total++;
         if (mem[a] !== mmem[a]) begin
            bad++;
            $display("FAIL R6 stack[%h]: act %h exp %h", a, mem[a], mmem[a]);
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R1 watchdog: act running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule